// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI function's configuration header. The master and target logic of the function report bus events to it as single-cycle pulses: a detected parity error, an asserted system error, a received master abort, a received target abort, a signaled target abort, and a PERR that is driven or sensed. The register latches each event into a sticky flag. Software clears a flag by writing 1 to it.

The remaining fields are fixed or follow configuration. The device-select timing field is constant. The fast back-to-back and capability-list bits follow two configuration straps. The master data parity flag sets only when its qualifying conditions hold together.

The read port shows the register contents combinationally. A configuration write, qualified per byte, takes effect at the next rising clock edge. Events also take effect at the next rising clock edge.

Top module: `pci_cfg_status`

## Requirements
- R1: `rd_data` shows the fields at these positions: bit 15 detected parity error, bit 14 signaled system error, bit 13 received master abort, bit 12 received target abort, bit 11 signaled target abort, bits 10:9 device-select timing, bit 8 master data parity error, bit 7 fast back-to-back capable, bit 4 capability list present.
- R2: A pulse on `evt_parity_det` sets bit 15 at the next clock edge, whatever the value of `cmd_parity_resp`.
- R3: A pulse on `evt_serr`, `evt_mabort_rcvd`, `evt_tabort_rcvd` or `evt_tabort_sig` sets bit 14, 13, 12 or 11 respectively at the next clock edge. The bit then stays set until it is cleared.
- R4: A write clears each sticky bit (15:11 and 8) whose data bit is 1. Data bits of 0 leave the register unchanged. A write never sets any bit.
- R5: Bit 8 sets only when `evt_perr_seen`, `is_master` and `cmd_parity_resp` are all 1 in the same cycle. If any one of them is 0, bit 8 does not set.
- R6: Bits 10:9 always read 01b, which is medium device-select timing. Writes have no effect on them.
- R7: Bit 7 equals `strap_fbb_en`. Writes have no effect on it.
- R8: Bit 4 equals `strap_cap_en`. Writes have no effect on it.
- R9: Bits 6, 5 and 3:0 always read 0, including after a write of all ones.
- R10: When an event and a write-1 clear reach the same bit in the same cycle, the bit is set after that edge.
- R11: `wr_be[1]` enables the write to bits 15:8 and `wr_be[0]` enables bits 7:0. A write whose byte enable is 0 does not change that byte.
- R12: A clock edge with `rst` high clears all sticky bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_parity_det | input | 1 | Parity error detected (pulse) |
| evt_serr | input | 1 | System error asserted (pulse) |
| evt_mabort_rcvd | input | 1 | Master abort received (pulse) |
| evt_tabort_rcvd | input | 1 | Target abort received (pulse) |
| evt_tabort_sig | input | 1 | Target abort signaled (pulse) |
| evt_perr_seen | input | 1 | PERR driven or sensed (pulse) |
| is_master | input | 1 | Function is bus master of the current transfer |
| cmd_parity_resp | input | 1 | Parity-response bit of the command register |
| strap_fbb_en | input | 1 | Fast back-to-back enable strap |
| strap_cap_en | input | 1 | Power-management / capability-list enable strap |
| wr_en | input | 1 | Configuration write strobe |
| wr_be | input | 2 | Byte enables of the write |
| wr_data | input | 16 | Write data, with 1 meaning clear |
| rd_data | output | 16 | Current status word |

## Verification
Events and writes are registered once, so their effect on `rd_data` is due exactly one rising edge after the cycle in which they are presented. The straps reach `rd_data` in the same cycle without a register. The driver holds each stimulus from one falling edge to the next and queues the expected word at the rising edge between them. The monitor compares that word one nanosecond after the same rising edge, so every comparison falls in the cycle where the result is due and before the inputs change again.

// File: rtl/pci_stat_pkg.sv
package pci_stat_pkg;
  localparam int STAT_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int N_BYTES  = STAT_W / BYTE_W;
  localparam int N_EVT    = 6;

  localparam int POS_DPE  = 15;
  localparam int POS_SSE  = 14;
  localparam int POS_RMA  = 13;
  localparam int POS_RTA  = 12;
  localparam int POS_STA  = 11;
  localparam int POS_DSEL = 9;
  localparam int POS_MDPE = 8;
  localparam int POS_FBB  = 7;
  localparam int POS_CAP  = 4;

  localparam logic [1:0] DSEL_MEDIUM = 2'b01;

  // Bit position of each sticky event slot in the status word.
  function automatic int evt_pos(input int idx);
    case (idx)
      0:       evt_pos = POS_MDPE;
      1:       evt_pos = POS_STA;
      2:       evt_pos = POS_RTA;
      3:       evt_pos = POS_RMA;
      4:       evt_pos = POS_SSE;
      default: evt_pos = POS_DPE;
    endcase
  endfunction

  // Next value of a sticky flag: the event has priority over the clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    sticky_next = set | (cur & ~clr);
  endfunction

  // A master data parity error counts only with all three qualifiers.
  function automatic logic mdpe_ok(input logic perr, input logic master, input logic resp);
    mdpe_ok = perr & master & resp;
  endfunction
endpackage

// File: rtl/pci_stat_clr_mask.sv
module pci_stat_clr_mask
  import pci_stat_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int BW = BYTE_W,
  localparam int NB = W / BW
) (
  input  logic          wr_en,
  input  logic [NB-1:0] wr_be,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  clr_mask
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign clr_mask[b*BW +: BW] = (wr_en && wr_be[b]) ? wr_data[b*BW +: BW] : '0;
  end
endmodule

// File: rtl/pci_stat_mdpe_qual.sv
module pci_stat_mdpe_qual
  import pci_stat_pkg::*;
(
  input  logic evt_perr_seen,
  input  logic is_master,
  input  logic cmd_parity_resp,
  output logic mdpe_set
);
  assign mdpe_set = mdpe_ok(evt_perr_seen, is_master, cmd_parity_resp);
endmodule

// File: rtl/pci_stat_evt_bank.sv
module pci_stat_evt_bank
  import pci_stat_pkg::*;
#(
  parameter int N = N_EVT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= sticky_next(q[i], set[i], clr[i]);
    end
  end
endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
  import pci_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_parity_det,
  input  logic              evt_serr,
  input  logic              evt_mabort_rcvd,
  input  logic              evt_tabort_rcvd,
  input  logic              evt_tabort_sig,
  input  logic              evt_perr_seen,
  input  logic              is_master,
  input  logic              cmd_parity_resp,
  input  logic              strap_fbb_en,
  input  logic              strap_cap_en,
  input  logic              wr_en,
  input  logic [N_BYTES-1:0] wr_be,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data
);
  logic              mdpe_set;
  logic [STAT_W-1:0] clr_mask;
  logic [N_EVT-1:0]  evt_set;
  logic [N_EVT-1:0]  evt_clr;
  logic [N_EVT-1:0]  evt_q;

  pci_stat_mdpe_qual u_qual (
    .evt_perr_seen   (evt_perr_seen),
    .is_master       (is_master),
    .cmd_parity_resp (cmd_parity_resp),
    .mdpe_set        (mdpe_set)
  );

  pci_stat_clr_mask #(.W(STAT_W), .BW(BYTE_W)) u_mask (
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .clr_mask (clr_mask)
  );

  assign evt_set = {evt_parity_det, evt_serr, evt_mabort_rcvd,
                    evt_tabort_rcvd, evt_tabort_sig, mdpe_set};

  for (genvar i = 0; i < N_EVT; i++) begin : g_clr
    assign evt_clr[i] = clr_mask[evt_pos(i)];
  end

  pci_stat_evt_bank #(.N(N_EVT)) u_bank (
    .clk (clk),
    .rst (rst),
    .set (evt_set),
    .clr (evt_clr),
    .q   (evt_q)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_EVT; i++) rd_data[evt_pos(i)] = evt_q[i];
    rd_data[POS_DSEL +: 2] = DSEL_MEDIUM;
    rd_data[POS_FBB]       = strap_fbb_en;
    rd_data[POS_CAP]       = strap_cap_en;
  end
endmodule

// File: rtl/pci_stat_chk.sv
module pci_stat_chk (
  input logic        clk,
  input logic        rst,
  input logic        evt_parity_det,
  input logic        evt_serr,
  input logic        evt_mabort_rcvd,
  input logic        evt_tabort_rcvd,
  input logic        evt_tabort_sig,
  input logic        evt_perr_seen,
  input logic        is_master,
  input logic        cmd_parity_resp,
  input logic        strap_fbb_en,
  input logic        strap_cap_en,
  input logic        wr_en,
  input logic [1:0]  wr_be,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        mdpe_set
);
  a_r2_dpe_sets: assert property (@(posedge clk) disable iff (rst)
    evt_parity_det |=> rd_data[15]);

  a_r3_sticky_sets: assert property (@(posedge clk) disable iff (rst)
    (evt_serr || evt_mabort_rcvd || evt_tabort_rcvd || evt_tabort_sig) |=>
      ((rd_data[14] || !$past(evt_serr)) && (rd_data[13] || !$past(evt_mabort_rcvd)) &&
       (rd_data[12] || !$past(evt_tabort_rcvd)) && (rd_data[11] || !$past(evt_tabort_sig))));

  a_r4_clear_serr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[1] && wr_data[14] && !evt_serr) |=> !rd_data[14]);

  a_r4_no_spont_set: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[13] && !evt_mabort_rcvd) |=> !rd_data[13]);

  a_r5_mdpe_needs_qual: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[8]) |-> $past(evt_perr_seen && is_master && cmd_parity_resp));

  a_r5_qual_port_level: assert property (@(posedge clk) disable iff (rst)
    mdpe_set |=> rd_data[8]);

  a_r6_devsel_medium: assert property (@(posedge clk) disable iff (rst)
    rd_data[10:9] == 2'b01);

  a_r7_fbb_strap: assert property (@(posedge clk) disable iff (rst)
    rd_data[7] == strap_fbb_en);

  a_r8_cap_strap: assert property (@(posedge clk) disable iff (rst)
    rd_data[4] == strap_cap_en);

  a_r9_fixed_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data[6:5] == 2'b00) && (rd_data[3:0] == 4'h0));

  a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
    (evt_parity_det && wr_en && wr_be[1] && wr_data[15]) |=> rd_data[15]);

  a_r11_be_gates: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_be[1] && rd_data[12]) |=> rd_data[12]);

  a_r12_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (rd_data[15:11] == 5'b0 && rd_data[8] == 1'b0));
endmodule

bind pci_cfg_status pci_stat_chk u_chk (.*);

// File: tb/pci_cfg_status_test.sv
`timescale 1ns/100ps
module pci_cfg_status_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_parity_det = 0, evt_serr = 0, evt_mabort_rcvd = 0;
  logic        evt_tabort_rcvd = 0, evt_tabort_sig = 0, evt_perr_seen = 0;
  logic        is_master = 0, cmd_parity_resp = 0;
  logic        strap_fbb_en = 0, strap_cap_en = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  pci_cfg_status uut (.*);

  typedef struct { logic [15:0] val; string tag; } exp_t;
  exp_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Model of the sticky flags, indexed by the bit position of R1.
  logic [15:0] m_flags = 16'h0;

  function automatic logic [15:0] word(input logic [15:0] f, input logic fbb, input logic cap);
    logic [15:0] w;
    w = f & 16'hF900;
    w[10:9] = 2'b01;
    w[7] = fbb;
    w[4] = cap;
    return w;
  endfunction

  // ev order: {dpe, serr, mabort, tabort_rcvd, tabort_sig, perr_seen}
  task automatic step(input logic [5:0] ev, input logic mst, input logic pr,
                      input logic fbb, input logic cap, input logic r,
                      input logic we, input logic [1:0] be, input logic [15:0] wd,
                      input string tag);
    logic [15:0] setv, clrv;
    exp_t e;
    @(negedge clk);
    {evt_parity_det, evt_serr, evt_mabort_rcvd, evt_tabort_rcvd, evt_tabort_sig, evt_perr_seen} = ev;
    is_master = mst; cmd_parity_resp = pr; strap_fbb_en = fbb; strap_cap_en = cap;
    rst = r; wr_en = we; wr_be = be; wr_data = wd;
    setv = 16'h0;
    setv[15] = ev[5]; setv[14] = ev[4]; setv[13] = ev[3];
    setv[12] = ev[2]; setv[11] = ev[1]; setv[8] = ev[0] & mst & pr;
    clrv = 16'h0;
    if (we && be[1]) clrv[15:8] = wd[15:8];
    if (r) m_flags = 16'h0;
    else   m_flags = (setv | (m_flags & ~clrv)) & 16'hF900;
    @(posedge clk);
    e.val = word(m_flags, fbb, cap);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(6'b0, 0, 0, 0, 0, 0, 0, 2'b00, 16'h0, tag);
  endtask

  // Monitor: compare 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (rd_data !== e.val) begin
          n_fail++;
          $display("FAIL %s: rd_data=%h expected=%h", e.tag, rd_data, e.val);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(6'b0, 0, 0, 0, 0, 1, 0, 2'b00, 16'h0, "R12 reset state");
    idle("R6 devsel after reset");
    step(6'b0, 0, 0, 1, 0, 0, 0, 2'b00, 16'h0, "R7 fbb strap high");
    step(6'b0, 0, 0, 0, 1, 0, 0, 2'b00, 16'h0, "R8 cap strap high");
    step(6'b0, 0, 0, 0, 0, 0, 1, 2'b11, 16'hFFFF, "R9 R4 write ones sets nothing");
    step(6'b100000, 0, 0, 0, 0, 0, 0, 2'b00, 16'h0, "R2 parity with response off");
    step(6'b010000, 0, 0, 0, 0, 0, 0, 2'b00, 16'h0, "R3 serr");
    step(6'b001000, 0, 0, 0, 0, 0, 0, 2'b00, 16'h0, "R3 master abort");
    step(6'b000100, 0, 0, 0, 0, 0, 0, 2'b00, 16'h0, "R3 target abort rcvd");
    step(6'b000010, 0, 0, 0, 0, 0, 0, 2'b00, 16'h0, "R3 target abort signaled");
    idle("R3 flags stay set");
    step(6'b000001, 1, 0, 0, 0, 0, 0, 2'b00, 16'h0, "R5 no response bit");
    step(6'b000001, 0, 1, 0, 0, 0, 0, 2'b00, 16'h0, "R5 not master");
    step(6'b000000, 1, 1, 0, 0, 0, 0, 2'b00, 16'h0, "R5 no perr");
    step(6'b000001, 1, 1, 1, 1, 0, 0, 2'b00, 16'h0, "R1 R5 all fields set");
    step(6'b0, 0, 0, 0, 0, 0, 1, 2'b11, 16'h0000, "R4 write zeros no change");
    step(6'b0, 0, 0, 0, 0, 0, 1, 2'b01, 16'hFFFF, "R11 low byte only");
    step(6'b0, 0, 0, 0, 0, 0, 1, 2'b10, 16'h4000, "R11 R4 clear serr");
    step(6'b010000, 0, 0, 0, 0, 0, 1, 2'b10, 16'h4000, "R10 event beats clear");
    step(6'b100000, 0, 0, 0, 0, 0, 1, 2'b10, 16'h7900, "R10 dpe kept others cleared");
    step(6'b0, 0, 0, 0, 0, 0, 1, 2'b11, 16'hFFFF, "R4 clear all");
    step(6'b111111, 1, 1, 0, 0, 0, 0, 2'b00, 16'h0, "R3 all events together");
    step(6'b111111, 1, 1, 0, 0, 1, 0, 2'b00, 16'h0, "R12 reset beats events");
    idle("R12 stays clear");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule